// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block sits between a set of interrupt-raising devices and a processor core. Each device presents a request line and a three-bit urgency level. The arbiter finds the most urgent pending request, with ties among devices at the same level resolved toward the smaller device number. It then compares that level with the level of the program the core is currently running. An interrupt is taken only when the winning request strictly outranks the running program. A device at the same level as the program, or at a lower one, never breaks in.

The core decides whether to leave the current program only at one point in its instruction cycle: after results are written back and before the next instruction is fetched. It marks that boundary with a one-cycle check strobe. The arbiter captures its decision on that strobe. It then presents a single-cycle take-interrupt pulse, together with the winning level and the winning device number, which the core uses to form an interrupt vector. Between strobes the level and device outputs hold their last captured values, whatever the requests do.

All pins are plain control and status signals. The block moves no data stream, so no valid/ready handshake is involved and there is no back-pressure. Input changes that do not coincide with a strobe have no effect on the outputs.

Top module: `irq_arbiter`

## Requirements
- R1: Each device d has a level field `dev_level[3*d +: 3]`, where 0 is the least urgent level and 7 the most urgent.
- R2: On a strobe, the captured `win_level` equals the largest level among the devices whose `req` bit is set.
- R3: `take_irq` pulses only when the captured winning level is strictly greater than the `cur_level` sampled with the strobe.
- R4: When the winning level equals `cur_level`, or is below it, `take_irq` stays low.
- R5: When several pending devices share the winning level, `win_dev` is the smallest such device number.
- R6: `win_level` and `win_dev` change only in the cycle after a strobe, and hold their values in every other cycle.
- R7: `take_irq` is high for exactly the one cycle that follows a strobe whose comparison succeeded, and it is low in all other cycles.
- R8: A strobe with no `req` bit set gives `take_irq` low, `win_level` 0 and `win_dev` 0.
- R9: While `rst_n` is low, all outputs are 0.
- R10: A device whose `req` bit is clear has no effect on the outcome, whatever its level field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | One pending-request bit per device |
| dev_level | input | 24 | Packed 3-bit level per device, device d at bits 3*d+2..3*d |
| cur_level | input | 3 | Level of the program the core is running |
| check_strobe | input | 1 | One-cycle marker of the boundary between writeback and fetch |
| take_irq | output | 1 | One-cycle pulse: the core should enter the service path |
| win_level | output | 3 | Level of the captured winning request |
| win_dev | output | 3 | Device number of the captured winning request |

## Verification
The hardest outcomes to reach from the ports are a tie at the top level, which exercises the lowest-index rule, and the boundary where the winning level equals the running level. Only particular combinations of request masks, level maps and `cur_level` produce them. The stimulus therefore applies all 256 request masks against all eight running levels, under level maps that are distinct, paired and fully tied. Between strobes it inverts the request mask, so that any leak of un-strobed inputs into the held outputs becomes visible.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_NUM_DEV = 8;
  localparam int DEF_LVL_W   = 3;
endpackage

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
  parameter int NUM_DEV = irq_arb_pkg::DEF_NUM_DEV,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level,
  output logic [LVL_W-1:0]         top_level,
  output logic                     any_pending
);
  logic [NUM_LVL-1:0] lvl_active;

  genvar l;
  generate
    for (l = 0; l < NUM_LVL; l++) begin : g_lvl
      logic [NUM_DEV-1:0] hit;
      always_comb begin
        for (int d = 0; d < NUM_DEV; d++)
          hit[d] = req[d] && (dev_level[d*LVL_W +: LVL_W] == LVL_W'(l));
      end
      assign lvl_active[l] = |hit;
    end
  endgenerate

  always_comb begin
    top_level = '0;
    for (int k = 0; k < NUM_LVL; k++)
      if (lvl_active[k]) top_level = LVL_W'(k);
  end

  assign any_pending = |lvl_active;
endmodule

// File: rtl/irq_dev_pick.sv
module irq_dev_pick #(
  parameter int NUM_DEV = irq_arb_pkg::DEF_NUM_DEV,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level,
  input  logic [LVL_W-1:0]         top_level,
  output logic [IDX_W-1:0]         pick_idx
);
  logic [NUM_DEV-1:0] cand;

  genvar d;
  generate
    for (d = 0; d < NUM_DEV; d++) begin : g_cand
      assign cand[d] = req[d] && (dev_level[d*LVL_W +: LVL_W] == top_level);
    end
  endgenerate

  always_comb begin
    pick_idx = '0;
    for (int k = NUM_DEV - 1; k >= 0; k--)
      if (cand[k]) pick_idx = IDX_W'(k);
  end
endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg #(
  parameter int LVL_W = irq_arb_pkg::DEF_LVL_W,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_strobe,
  input  logic             any_pending,
  input  logic [LVL_W-1:0] top_level,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic [LVL_W-1:0] cur_level,
  output logic             take_irq,
  output logic [LVL_W-1:0] win_level,
  output logic [IDX_W-1:0] win_dev
);
  logic outranks;
  assign outranks = any_pending && (top_level > cur_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_irq  <= 1'b0;
      win_level <= '0;
      win_dev   <= '0;
    end else begin
      take_irq <= check_strobe && outranks;
      if (check_strobe) begin
        win_level <= any_pending ? top_level : '0;
        win_dev   <= any_pending ? pick_idx  : '0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_DEV = irq_arb_pkg::DEF_NUM_DEV,
  parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level,
  input  logic [LVL_W-1:0]         cur_level,
  input  logic                     check_strobe,
  output logic                     take_irq,
  output logic [LVL_W-1:0]         win_level,
  output logic [IDX_W-1:0]         win_dev
);
  logic [LVL_W-1:0] top_level;
  logic             any_pending;
  logic [IDX_W-1:0] pick_idx;

  irq_level_scan #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_scan (
    .req(req), .dev_level(dev_level),
    .top_level(top_level), .any_pending(any_pending)
  );

  irq_dev_pick #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_pick (
    .req(req), .dev_level(dev_level),
    .top_level(top_level), .pick_idx(pick_idx)
  );

  irq_gate_reg #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .check_strobe(check_strobe),
    .any_pending(any_pending), .top_level(top_level), .pick_idx(pick_idx),
    .cur_level(cur_level), .take_irq(take_irq),
    .win_level(win_level), .win_dev(win_dev)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_DEV-1:0]       req,
  input logic [LVL_W-1:0]         cur_level,
  input logic                     check_strobe,
  input logic                     take_irq,
  input logic [LVL_W-1:0]         win_level,
  input logic [IDX_W-1:0]         win_dev
);
  AST_TAKE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(check_strobe)); // R7

  AST_TAKE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (win_level > $past(cur_level))); // R3

  AST_NO_TAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(check_strobe) && (win_level <= $past(cur_level))) |-> !take_irq); // R4

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(check_strobe) |-> ($stable(win_level) && $stable(win_dev))); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(check_strobe) && ($past(req) == '0)) |-> (!take_irq && win_level == '0 && win_dev == '0)); // R8

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(check_strobe) && ($past(req) != '0)) |-> ((($past(req) >> win_dev) & 1) != 0)); // R10
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cur_level(cur_level),
  .check_strobe(check_strobe), .take_irq(take_irq),
  .win_level(win_level), .win_dev(win_dev)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [23:0] dev_level = '0;
  logic [2:0]  cur_level = '0;
  logic        check_strobe = 1'b0;
  logic        take_irq;
  logic [2:0]  win_level;
  logic [2:0]  win_dev;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_level(dev_level),
    .cur_level(cur_level), .check_strobe(check_strobe),
    .take_irq(take_irq), .win_level(win_level), .win_dev(win_dev)
  );

  task automatic chk(input string rq, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int lvl_of(input int scheme, input int d);
    case (scheme)
      0: return (d * 3 + 1) % 8;
      1: return (d * 5 + 6) % 8;
      2: return ((d >> 1) * 3 + 2) % 8;
      default: return 4;
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R9: reset state, checked with a strobe and requests active during reset
    @(negedge clk);
    req = 8'hFF; dev_level = {8{3'd7}}; check_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 take_irq", take_irq, 0);
    chk("R9 win_level", win_level, 0);
    chk("R9 win_dev", win_dev, 0);
    check_strobe = 1'b0; req = '0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int m = 0; m < 256; m++) begin
          int exp_lvl, exp_dev, exp_take;
          bit any;
          any = 1'b0; exp_lvl = 0; exp_dev = 0;
          for (int d = 0; d < 8; d++) begin
            dev_level[d*3 +: 3] = 3'(lvl_of(s, d));
            if (m[d] && (!any || lvl_of(s, d) > exp_lvl)) begin
              any = 1'b1; exp_lvl = lvl_of(s, d); exp_dev = d;
            end
          end
          exp_take = (any && exp_lvl > c) ? 1 : 0;
          req = 8'(m); cur_level = 3'(c); check_strobe = 1'b1;
          @(negedge clk);
          check_strobe = 1'b0;
          // R3/R4 strict compare; R8 idle; R2 max level; R5 tie; R10 masked ignored
          chk(exp_take ? "R3 take_irq" : "R4 take_irq", take_irq, exp_take);
          chk(any ? "R2 R10 win_level" : "R8 win_level", win_level, exp_lvl);
          chk(any ? "R5 R10 win_dev" : "R8 win_dev", win_dev, exp_dev);
          req = ~8'(m); cur_level = ~3'(c);
          @(negedge clk);
          // R7 single pulse; R6 hold without strobe
          chk("R7 take_irq pulse end", take_irq, 0);
          chk("R6 win_level hold", win_level, exp_lvl);
          chk("R6 win_dev hold", win_dev, exp_dev);
        end
      end
    end

    // R1: each field position decoded independently, one device at top level
    for (int d = 0; d < 8; d++) begin
      dev_level = '0;
      dev_level[d*3 +: 3] = 3'd7;
      req = 8'hFF; cur_level = 3'd6; check_strobe = 1'b1;
      @(negedge clk);
      check_strobe = 1'b0;
      chk("R1 win_dev field", win_dev, d);
      chk("R1 win_level field", win_level, 7);
      chk("R1 take_irq field", take_irq, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule